// File: doc/BRIEF.md
# Processor Operating-Mode Controller

This block follows the operating mode of an x86-style core. Level inputs mirror the control bits that govern the mode: protection enable, paging enable, address-extension enable, long-mode enable, the virtual-machine flag and the long bit of the current code segment. Two single-cycle events, a management interrupt and a resume, enter and leave system-management mode. The block registers the mode and reports it as a one-hot vector. It also reports a long-mode-active flag, the default address and operand sizes of the current mode, and a one-cycle pulse whenever a request is refused.

All inputs are sampled on the rising clock edge. Every output changes on the same edge that samples the stimulus causing the change. Reset is synchronous and active high. While the block is in system-management mode it ignores the level inputs, and it resumes into the mode that was interrupted.

Top module: `opmode_ctrl`

## Requirements
- R1: Reset forces real mode and holds the error pulse low. Exactly one bit of `mode_onehot` is set at all times. The bit positions are: 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit, 5 system-management.
- R2: In real mode, `prot_en`=1 moves the block to protected mode. In protected mode, `prot_en`=0 returns it to real mode.
- R3: In protected mode with `prot_en`=1, `virt_flag`=1 enters virtual-8086 mode. In virtual-8086 mode, `virt_flag`=0 returns the block to protected mode.
- R4: Long mode is entered only from protected mode, and only on a cycle where `page_en` rises from 0 to 1 while `long_en` and `addr_ext_en` are both 1. If `page_en` rises while `long_en`=1 and `addr_ext_en`=0, the block stays in protected mode and pulses `req_ignored`. If `page_en` rises while `long_en`=0, the block stays in protected mode and raises no error.
- R5: While in long mode with paging on, `cs_long`=1 selects 64-bit mode and `cs_long`=0 selects compatibility mode. The bit is re-evaluated on every cycle.
- R6: Clearing `page_en` in long mode returns the block to protected mode. Clearing `long_en` afterwards leaves the block in protected mode.
- R7: `mgmt_int` outside system-management mode enters that mode and saves the current mode. In system-management mode the level inputs have no effect, and `mgmt_resume` restores the saved mode.
- R8: In long mode, a rise of `virt_flag` pulses `req_ignored` and leaves the mode unchanged. From long mode the next mode is never real or virtual-8086.
- R9: `addr_size` and `opnd_size` use the codes 0 = 16 bits, 1 = 32 bits, 2 = 64 bits. The pairs (address, operand) are: 64-bit mode gives 2/1; compatibility and protected modes give 1/1; real, virtual-8086 and system-management modes give 0/0.
- R10: `mgmt_resume` outside system-management mode is ignored and pulses `req_ignored` for one cycle.
- R11: `mgmt_int` while already in system-management mode is ignored: the mode stays and `req_ignored` pulses.
- R12: `long_active` is 1 exactly when the mode is compatibility or 64-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prot_en | input | 1 | Protection enable level |
| page_en | input | 1 | Paging enable level |
| addr_ext_en | input | 1 | Physical-address-extension enable level |
| long_en | input | 1 | Long-mode enable level |
| virt_flag | input | 1 | Virtual-machine flag level |
| cs_long | input | 1 | Long bit of the current code segment |
| mgmt_int | input | 1 | Management interrupt event, one cycle |
| mgmt_resume | input | 1 | Resume-from-management event, one cycle |
| mode_onehot | output | 6 | Current mode, one-hot |
| long_active | output | 1 | Long mode (either submode) active |
| addr_size | output | SZ_W | Default address size code |
| opnd_size | output | SZ_W | Default operand size code |
| req_ignored | output | 1 | One-cycle pulse for a refused request |

## Verification
The assertions check the following on every cycle:
- the one-hot shape of the mode;
- that long mode is only ever entered from protected mode with the enables in place;
- that real and virtual-8086 modes never directly follow long mode;
- that stray management events raise the error pulse;
- that 64-bit mode reports its size pair.

Only the bench scenarios can show the following:
- the full ordering story, including paging turned on before address extension and paging rising with long mode disabled;
- submode switching by the segment bit;
- the saved mode surviving a level change made during system-management mode;
- reset out of a non-real mode.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
   localparam int MODE_N = 6;
   localparam int CODE_W = 2;

   typedef enum logic [2:0] {
      M_REAL   = 3'd0,
      M_PROT   = 3'd1,
      M_V86    = 3'd2,
      M_COMPAT = 3'd3,
      M_B64    = 3'd4,
      M_SMM    = 3'd5
   } mode_e;

   localparam logic [CODE_W-1:0] SZ16 = 2'd0;
   localparam logic [CODE_W-1:0] SZ32 = 2'd1;
   localparam logic [CODE_W-1:0] SZ64 = 2'd2;

   function automatic logic [CODE_W-1:0] addr_code(input int m);
      case (m)
         4:       return SZ64;
         1, 3:    return SZ32;
         default: return SZ16;
      endcase
   endfunction

   function automatic logic [CODE_W-1:0] opnd_code(input int m);
      case (m)
         1, 3, 4: return SZ32;
         default: return SZ16;
      endcase
   endfunction
endpackage

// File: rtl/opmode_step.sv
module opmode_step
   import opmode_pkg::*;
(
   input  mode_e cur,
   input  mode_e saved,
   input  logic  pe,
   input  logic  pg,
   input  logic  pg_rise,
   input  logic  pae,
   input  logic  lme,
   input  logic  vm,
   input  logic  vm_rise,
   input  logic  csl,
   input  logic  smi,
   input  logic  rsm,
   output mode_e nxt,
   output logic  save_en,
   output logic  err
);
   always_comb begin
      nxt     = cur;
      save_en = 1'b0;
      err     = 1'b0;
      if (cur == M_SMM) begin
         if (rsm) nxt = saved;
         if (smi) err = 1'b1;
      end else begin
         if (rsm) err = 1'b1;
         if (smi) begin
            nxt     = M_SMM;
            save_en = 1'b1;
         end else begin
            case (cur)
               M_REAL: if (pe) nxt = M_PROT;
               M_PROT: begin
                  if (!pe)
                     nxt = M_REAL;
                  else if (vm)
                     nxt = M_V86;
                  else if (pg_rise) begin
                     if (lme && pae)
                        nxt = csl ? M_B64 : M_COMPAT;
                     else if (lme)
                        err = 1'b1;
                  end
               end
               M_V86: if (!vm) nxt = M_PROT;
               M_COMPAT, M_B64: begin
                  if (!pg)
                     nxt = M_PROT;
                  else begin
                     nxt = csl ? M_B64 : M_COMPAT;
                     if (vm_rise) err = 1'b1;
                  end
               end
               default: nxt = M_REAL;
            endcase
         end
      end
   end
endmodule

// File: rtl/opmode_size_dec.sv
module opmode_size_dec
   import opmode_pkg::*;
#(
   parameter int SZ_W = 2
) (
   input  logic [MODE_N-1:0] mode_oh,
   output logic [SZ_W-1:0]   addr_sz,
   output logic [SZ_W-1:0]   opnd_sz
);
   generate
      if (SZ_W < CODE_W) begin : g_bad_width
         $error("opmode_size_dec: SZ_W must hold a size code");
      end
   endgenerate

   logic [SZ_W-1:0] a_part [MODE_N];
   logic [SZ_W-1:0] o_part [MODE_N];

   for (genvar g = 0; g < MODE_N; g++) begin : g_mode
      localparam logic [SZ_W-1:0] A_C = SZ_W'(addr_code(g));
      localparam logic [SZ_W-1:0] O_C = SZ_W'(opnd_code(g));
      assign a_part[g] = mode_oh[g] ? A_C : '0;
      assign o_part[g] = mode_oh[g] ? O_C : '0;
   end

   always_comb begin
      addr_sz = '0;
      opnd_sz = '0;
      for (int i = 0; i < MODE_N; i++) begin
         addr_sz = addr_sz | a_part[i];
         opnd_sz = opnd_sz | o_part[i];
      end
   end
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
   import opmode_pkg::*;
#(
   parameter int SZ_W = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            prot_en,
   input  logic            page_en,
   input  logic            addr_ext_en,
   input  logic            long_en,
   input  logic            virt_flag,
   input  logic            cs_long,
   input  logic            mgmt_int,
   input  logic            mgmt_resume,
   output logic [5:0]      mode_onehot,
   output logic            long_active,
   output logic [SZ_W-1:0] addr_size,
   output logic [SZ_W-1:0] opnd_size,
   output logic            req_ignored
);
   localparam int IDX_REAL = int'(M_REAL);
   localparam int IDX_PROT = int'(M_PROT);
   localparam int IDX_V86  = int'(M_V86);
   localparam int IDX_CMP  = int'(M_COMPAT);
   localparam int IDX_B64  = int'(M_B64);
   localparam int IDX_SMM  = int'(M_SMM);

   generate
      if (MODE_N != 6) begin : g_bad_modes
         $error("opmode_ctrl: mode vector width mismatch");
      end
   endgenerate

   mode_e mode_q, saved_q, nxt;
   logic  pg_q, vm_q, err_q, save_en, err_n;

   opmode_step i_step (
      .cur     (mode_q),
      .saved   (saved_q),
      .pe      (prot_en),
      .pg      (page_en),
      .pg_rise (page_en & ~pg_q),
      .pae     (addr_ext_en),
      .lme     (long_en),
      .vm      (virt_flag),
      .vm_rise (virt_flag & ~vm_q),
      .csl     (cs_long),
      .smi     (mgmt_int),
      .rsm     (mgmt_resume),
      .nxt     (nxt),
      .save_en (save_en),
      .err     (err_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q  <= M_REAL;
         saved_q <= M_REAL;
         pg_q    <= 1'b0;
         vm_q    <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         mode_q <= nxt;
         if (save_en) saved_q <= mode_q;
         pg_q   <= page_en;
         vm_q   <= virt_flag;
         err_q  <= err_n;
      end
   end

   for (genvar g = 0; g < MODE_N; g++) begin : g_oh
      assign mode_onehot[g] = (mode_q == mode_e'(g));
   end

   assign long_active = mode_onehot[IDX_CMP] | mode_onehot[IDX_B64];
   assign req_ignored = err_q;

   opmode_size_dec #(.SZ_W(SZ_W)) i_size (
      .mode_oh (mode_onehot),
      .addr_sz (addr_size),
      .opnd_sz (opnd_size)
   );

   // R1
   reset_real_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mode_onehot == 6'b000001 && !req_ignored));
   // R1
   onehot_mode_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(mode_onehot) == 1);
   // R4
   long_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (!long_active && !mode_onehot[IDX_SMM]) |=>
      (!long_active || $past(mode_onehot[IDX_PROT] && page_en && long_en && addr_ext_en)));
   // R8
   long_no_legacy_chk: assert property (@(posedge clk) disable iff (rst)
      long_active |=> !(mode_onehot[IDX_REAL] || mode_onehot[IDX_V86]));
   // R7
   smm_enter_chk: assert property (@(posedge clk) disable iff (rst)
      (mgmt_int && !mode_onehot[IDX_SMM]) |=> mode_onehot[IDX_SMM]);
   // R10
   stray_resume_chk: assert property (@(posedge clk) disable iff (rst)
      (mgmt_resume && !mode_onehot[IDX_SMM]) |=> req_ignored);
   // R11
   smi_in_smm_chk: assert property (@(posedge clk) disable iff (rst)
      (mgmt_int && !mgmt_resume && mode_onehot[IDX_SMM]) |=>
      (mode_onehot[IDX_SMM] && req_ignored));
   // R9
   size_b64_chk: assert property (@(posedge clk) disable iff (rst)
      mode_onehot[IDX_B64] |-> (addr_size == SZ_W'(2) && opnd_size == SZ_W'(1)));
endmodule

// File: tb/test_opmode_ctrl.sv
module test_opmode_ctrl;
   localparam int SZ_W = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pe = 0, pg = 0, pae = 0, lme = 0, vm = 0, csl = 0, smi = 0, rsm = 0;
   logic [5:0]      oh;
   logic            lact, ierr;
   logic [SZ_W-1:0] asz, osz;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   int    exp_mode_q [$];
   bit    exp_err_q  [$];
   string tag_q      [$];

   always #2 clk = ~clk;

   opmode_ctrl #(.SZ_W(SZ_W)) i_opmode_ctrl (
      .clk(clk), .rst(rst), .prot_en(pe), .page_en(pg), .addr_ext_en(pae),
      .long_en(lme), .virt_flag(vm), .cs_long(csl), .mgmt_int(smi),
      .mgmt_resume(rsm), .mode_onehot(oh), .long_active(lact),
      .addr_size(asz), .opnd_size(osz), .req_ignored(ierr)
   );

   // mode index: 0 real 1 prot 2 v86 3 compat 4 b64 5 smm (R1, R9, R12)
   function automatic int exp_addr(input int m);
      return (m == 4) ? 2 : ((m == 1 || m == 3) ? 1 : 0);
   endfunction
   function automatic int exp_opnd(input int m);
      return (m == 1 || m == 3 || m == 4) ? 1 : 0;
   endfunction

   task automatic step(input bit s_pe, s_pg, s_pae, s_lme, s_vm, s_csl, s_smi, s_rsm,
                       input int exp_m, input bit exp_e, input string tag);
      @(negedge clk);
      rst = 0;
      pe = s_pe; pg = s_pg; pae = s_pae; lme = s_lme;
      vm = s_vm; csl = s_csl; smi = s_smi; rsm = s_rsm;
      exp_mode_q.push_back(exp_m);
      exp_err_q.push_back(exp_e);
      tag_q.push_back(tag);
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst = 1;
      {pe, pg, pae, lme, vm, csl, smi, rsm} = '0;
      exp_mode_q.push_back(0);
      exp_err_q.push_back(1'b0);
      tag_q.push_back(tag);
   endtask

   // monitor: pops one expected item per clock and compares
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_mode_q.size() != 0) begin
            int    m;
            bit    e;
            string t;
            logic [5:0] eoh;
            bit         el;
            m = exp_mode_q.pop_front();
            e = exp_err_q.pop_front();
            t = tag_q.pop_front();
            eoh = 6'(1) << m;
            el  = (m == 3 || m == 4);
            checks++;
            if (oh !== eoh || ierr !== e || lact !== el ||
                asz !== SZ_W'(exp_addr(m)) || osz !== SZ_W'(exp_opnd(m))) begin
               errors++;
               $display("FAIL %s: got mode=%b err=%b long=%b asz=%0d osz=%0d exp mode=%b err=%b long=%b asz=%0d osz=%0d",
                        t, oh, ierr, lact, asz, osz, eoh, e, el, exp_addr(m), exp_opnd(m));
            end
         end
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang exp completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      //         pe pg pae lme vm csl smi rsm
      do_reset("R1 reset state");
      step(0,0,0,0,0,0,0,1, 0, 1, "R10 resume in real");
      step(1,0,0,0,0,0,0,0, 1, 0, "R2 enter protected");
      step(1,0,0,0,1,0,0,0, 2, 0, "R3 enter v86");
      step(1,0,0,0,0,0,0,0, 1, 0, "R3 leave v86");
      step(0,0,0,0,0,0,0,0, 0, 0, "R2 back to real");
      step(1,0,0,0,0,0,0,0, 1, 0, "R2 protected again");
      step(1,1,0,0,0,0,0,0, 1, 0, "R4 legacy paging");
      step(1,0,0,0,0,0,0,0, 1, 0, "R4 paging off");
      step(1,1,0,1,0,0,0,0, 1, 1, "R4 paging before extension");
      step(1,0,1,1,0,0,0,0, 1, 0, "R4 paging off again");
      step(1,1,1,1,0,0,0,0, 3, 0, "R4 R5 R12 enter compat");
      step(1,1,1,1,0,1,0,0, 4, 0, "R5 R9 64-bit");
      step(1,1,1,1,0,0,0,0, 3, 0, "R5 back to compat");
      step(1,1,1,1,0,1,0,0, 4, 0, "R5 64-bit again");
      step(1,1,1,1,1,1,0,0, 4, 1, "R8 vm rise ignored");
      step(1,1,1,1,1,1,0,0, 4, 0, "R8 vm held");
      step(1,1,1,1,0,1,1,0, 5, 0, "R7 smi from 64-bit");
      step(1,1,1,1,0,1,1,0, 5, 1, "R11 smi in smm");
      step(1,0,1,1,0,0,0,0, 5, 0, "R7 levels ignored in smm");
      step(1,1,1,1,0,1,0,1, 4, 0, "R7 resume to 64-bit");
      step(1,0,1,1,0,1,0,0, 1, 0, "R6 paging off leaves long");
      step(1,0,1,0,0,1,0,0, 1, 0, "R6 long enable cleared");
      step(0,0,0,0,0,0,0,0, 0, 0, "R2 real");
      step(0,0,0,0,0,0,1,0, 5, 0, "R7 smi from real");
      step(1,0,0,0,0,0,0,1, 0, 0, "R7 resume to real");
      step(1,0,0,0,0,0,0,0, 1, 0, "R2 protected before reset");
      do_reset("R1 reset from protected");
      step(0,0,0,0,0,0,0,0, 0, 0, "R1 real after reset");
      repeat (4) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule